// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block sits between a small 8-bit processor core and its external memories. The core issues one request at a time: a code fetch, a data read or a data write, each with a 16-bit address. The block turns each request into a fixed sequence of bus cycles. A shared byte lane first carries the low address byte and then the data. A separate lane carries the high address byte. An active-high latch strobe marks the address phase, so that an external transparent latch can hold the low address byte. Code fetches use their own active-low read strobe. Data space has separate active-low read and write strobes. Code space and data space are each 64K bytes.

A mode input selects where low code addresses go. When it is high, code fetches below 4K are served from an internal ROM port, and the external bus stays quiet. When it is low, every code fetch goes to the external bus. Data accesses always go external. The shared lane is split into an output value, an output enable and an input value, so that a pad ring can build the tri-state pin from them. Read data comes back on `rdata`, together with a one-cycle `done` pulse.

Top module: `xbus_ctrl`

## Requirements
- R1: While and right after reset, `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1, `ad_oe` is 0, `done` is 0 and `req_ready` is 1.
- R2: An external access starts with `ale` high for ADDR_CYC cycles (default 2). During that time `ad_out` carries address bits 7..0 with `ad_oe` high and `hi_addr` carries bits 15..8. When `ale` falls, the lane still holds the same low byte, so a latch that captures on that falling edge holds the full request address.
- R3: An external code fetch (`req_space`=0) drives `psen_n` low for STRB_CYC cycles (default 3). During that time the lane is released (`ad_oe`=0). `rdata` is the value on `ad_in` in the last cycle of the strobe.
- R4: An external data read (`req_space`=1, `req_we`=0) drives `rd_n` low for STRB_CYC cycles with the lane released. It returns the lane value in the same way as R3.
- R5: A data write (`req_space`=1, `req_we`=1) drives `wr_n` low for STRB_CYC cycles. During the strobe and in the following cycle, when `wr_n` rises, the lane is driven with `req_wdata`.
- R6: With `ext_only_n`=0, every code fetch goes to the external bus, including addresses 0x0000 to 0x0FFF.
- R7: With `ext_only_n`=1, a code fetch at an address below 0x1000 is served from the internal ROM. The block presents address bits 11..0 on `rom_addr` and returns `rom_data` on `rdata`. No strobe and no `ale` is asserted. `done` comes 2 cycles after acceptance. Address 0x1000 and above go external.
- R8: At most one of `ale`, not-`psen_n`, not-`rd_n` and not-`wr_n` is asserted in any cycle.
- R9: `hi_addr` stays equal to the latched high address byte for every cycle in which a strobe is asserted.
- R10: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is low for the whole access: 7 cycles for an external access with the default parameters, 2 for an internal one. `done` is high for exactly one cycle, at the end. A request held valid while the block is busy starts no second access.
- R11: Data accesses never assert `psen_n`, even below 0x1000. A code request with `req_we`=1 is still a read with `psen_n`: `wr_n` stays high and data memory is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_only_n | input | 1 | Low: all code fetches external; high: code below 4K from internal ROM |
| req_valid | input | 1 | Request present |
| req_space | input | 1 | 0 = code space, 1 = data space |
| req_we | input | 1 | 1 = write (data space only) |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Idle, able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read data, valid with done |
| rom_addr | output | 12 | Internal ROM address |
| rom_data | input | 8 | Internal ROM data |
| ad_out | output | 8 | Shared lane output value (low address, then write data) |
| ad_oe | output | 1 | Shared lane output enable |
| ad_in | input | 8 | Shared lane value seen at the pins |
| hi_addr | output | 8 | High address byte lane |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
Code fetches run at addresses on both sides of the 4K boundary (0x0FFF, 0x1000) and with both settings of the mode input. This tells the internal-ROM path apart from the external path, and shows that the mode input, not the address alone, picks the route. Data writes to two addresses with different high bytes, followed by reads back, show that the latched address and the write data reach the memory model. A data read below 4K and a code request with the write bit set show that the space, not the address or write bit, picks the strobe. A request held valid through a whole access shows that no second access starts. Each access is also checked for strobe lengths, lane direction during the strobe and high-byte stability.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int HI_W   = ADDR_W - DATA_W;

    typedef enum logic [1:0] {
        STB_PSEN = 2'd0,
        STB_RD   = 2'd1,
        STB_WR   = 2'd2
    } strobe_e;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ADDR = 3'd1,
        PH_HOLD = 3'd2,
        PH_STRB = 3'd3,
        PH_DONE = 3'd4,
        PH_IROM = 3'd5
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        strobe_e           stb;
        logic              internal;
    } xreq_t;

    // code fetch served by the on-chip ROM port
    function automatic logic serve_inside(input logic is_data,
                                          input logic [ADDR_W-1:0] a,
                                          input logic ext_only_n,
                                          input int unsigned limit);
        return !is_data && ext_only_n && (32'(a) < limit);
    endfunction

    // code space is read-only, so the write bit only counts for data
    function automatic strobe_e pick_strobe(input logic is_data, input logic we);
        if (!is_data) return STB_PSEN;
        if (we)       return STB_WR;
        return STB_RD;
    endfunction

endpackage

// File: rtl/xbus_route.sv
module xbus_route
    import xbus_pkg::*;
#(
    parameter int unsigned IROM_BYTES = 4096
) (
    input  logic              req_space,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ext_only_n,
    output xreq_t             req_out
);

    always_comb begin
        req_out.addr     = req_addr;
        req_out.wdata    = req_wdata;
        req_out.stb      = pick_strobe(req_space, req_we);
        req_out.internal = serve_inside(req_space, req_addr, ext_only_n, IROM_BYTES);
    end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int ADDR_CYC = 2,
    parameter int STRB_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  xreq_t             req_in,
    input  logic [DATA_W-1:0] ad_in,
    input  logic [DATA_W-1:0] rom_data,
    output phase_e            phase,
    output xreq_t             cur,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);

    localparam int MAX_CYC = (ADDR_CYC > STRB_CYC) ? ADDR_CYC : STRB_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            cur   <= '0;
            rdata <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        cur   <= req_in;
                        cnt   <= CNT_W'(ADDR_CYC - 1);
                        phase <= req_in.internal ? PH_IROM : PH_ADDR;
                    end
                end
                PH_ADDR: begin
                    if (cnt == '0) phase <= PH_HOLD;
                    else           cnt   <= cnt - 1'b1;
                end
                PH_HOLD: begin
                    cnt   <= CNT_W'(STRB_CYC - 1);
                    phase <= PH_STRB;
                end
                PH_STRB: begin
                    if (cnt == '0) begin
                        phase <= PH_DONE;
                        if (cur.stb != STB_WR) rdata <= ad_in;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_IROM: begin
                    rdata <= rom_data;
                    phase <= PH_DONE;
                end
                PH_DONE: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign req_ready = (phase == PH_IDLE);
    assign done      = (phase == PH_DONE);

    // R1: idle state right after reset
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !done));

    // R10: completion is a single-cycle pulse followed by idle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && req_ready));

    // R10: no new access is taken while busy
    a_r10_busy_hold: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !done) |=> $stable(cur));

endmodule

// File: rtl/xbus_lane.sv
module xbus_lane
    import xbus_pkg::*;
#(
    parameter int unsigned IROM_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  xreq_t             cur,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [HI_W-1:0]   hi_addr,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [$clog2(IROM_BYTES)-1:0] rom_addr
);

    localparam int IROM_AW = $clog2(IROM_BYTES);

    logic on_bus;
    logic addr_ph;
    logic strb_ph;
    logic wr_acc;

    always_comb begin
        addr_ph  = (phase == PH_ADDR) || (phase == PH_HOLD);
        strb_ph  = (phase == PH_STRB);
        on_bus   = addr_ph || strb_ph || ((phase == PH_DONE) && !cur.internal);
        wr_acc   = (cur.stb == STB_WR);

        ale      = (phase == PH_ADDR);
        psen_n   = !(strb_ph && cur.stb == STB_PSEN);
        rd_n     = !(strb_ph && cur.stb == STB_RD);
        wr_n     = !(strb_ph && wr_acc);

        ad_oe    = addr_ph || (on_bus && !addr_ph && wr_acc);
        if (addr_ph)                 ad_out = cur.addr[DATA_W-1:0];
        else if (on_bus && wr_acc)   ad_out = cur.wdata;
        else                         ad_out = '0;

        hi_addr  = on_bus ? cur.addr[ADDR_W-1:DATA_W] : '0;
        rom_addr = cur.addr[IROM_AW-1:0];
    end

    // R8: strobes and the latch strobe are mutually exclusive
    a_r8_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $countones({ale, !psen_n, !rd_n, !wr_n}) <= 1);

    // R3 / R4: lane released while a read strobe is low
    a_r3_lane_free: assert property (@(posedge clk) disable iff (rst)
        (!psen_n || !rd_n) |-> !ad_oe);

    // R5: lane driven while the write strobe is low
    a_r5_lane_write: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> ad_oe);

    // R2: low address still on the lane when the latch strobe falls
    a_r2_addr_hold: assert property (@(posedge clk) disable iff (rst)
        $fell(ale) |-> (ad_oe && ad_out == $past(ad_out) && hi_addr == $past(hi_addr)));

    // R7: internal ROM service leaves the external bus idle
    a_r7_no_bus_internal: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IROM) |-> (!ale && psen_n && rd_n && wr_n));

    // R9: high address byte steady across a strobe
    a_r9_hi_steady: assert property (@(posedge clk) disable iff (rst)
        ((!psen_n || !rd_n || !wr_n) && $past(!psen_n || !rd_n || !wr_n)) |-> $stable(hi_addr));

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int          ADDR_CYC   = 2,
    parameter int          STRB_CYC   = 3,
    parameter int unsigned IROM_BYTES = 4096
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ext_only_n,
    input  logic        req_valid,
    input  logic        req_space,
    input  logic        req_we,
    input  logic [15:0] req_addr,
    input  logic [7:0]  req_wdata,
    output logic        req_ready,
    output logic        done,
    output logic [7:0]  rdata,
    output logic [$clog2(IROM_BYTES)-1:0] rom_addr,
    input  logic [7:0]  rom_data,
    output logic [7:0]  ad_out,
    output logic        ad_oe,
    input  logic [7:0]  ad_in,
    output logic [7:0]  hi_addr,
    output logic        ale,
    output logic        psen_n,
    output logic        rd_n,
    output logic        wr_n
);

    xreq_t  routed;
    xreq_t  cur;
    phase_e phase;

    xbus_route #(.IROM_BYTES(IROM_BYTES)) u_route (
        .req_space  (req_space),
        .req_we     (req_we),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .ext_only_n (ext_only_n),
        .req_out    (routed)
    );

    xbus_seq #(.ADDR_CYC(ADDR_CYC), .STRB_CYC(STRB_CYC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_in    (routed),
        .ad_in     (ad_in),
        .rom_data  (rom_data),
        .phase     (phase),
        .cur       (cur),
        .req_ready (req_ready),
        .done      (done),
        .rdata     (rdata)
    );

    xbus_lane #(.IROM_BYTES(IROM_BYTES)) u_lane (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .cur      (cur),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe),
        .hi_addr  (hi_addr),
        .ale      (ale),
        .psen_n   (psen_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .rom_addr (rom_addr)
    );

endmodule

// File: tb/xbus_ctrl_test.sv
`timescale 1ns/1ps
module xbus_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_only_n = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_space = 1'b0;
    logic        req_we = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, done;
    logic [7:0]  rdata;
    logic [11:0] rom_addr;
    logic [7:0]  rom_data;
    logic [7:0]  ad_out, ad_in, hi_addr;
    logic        ad_oe, ale, psen_n, rd_n, wr_n;

    always #4 clk = ~clk;   // 125 MHz

    xbus_ctrl uut (
        .clk(clk), .rst(rst), .ext_only_n(ext_only_n),
        .req_valid(req_valid), .req_space(req_space), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rdata(rdata),
        .rom_addr(rom_addr), .rom_data(rom_data),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .hi_addr(hi_addr),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    // behavioural memories
    function automatic logic [7:0] code_val(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction
    function automatic logic [7:0] rom_val(input logic [11:0] a);
        return ~a[7:0] ^ {4'h0, a[11:8]};
    endfunction

    logic [7:0]  dmem [0:255];
    logic [15:0] latched = '0;
    logic        ale_d = 1'b0;
    logic        wr_d = 1'b1;
    logic [7:0]  exp_wdata = '0;

    assign rom_data = rom_val(rom_addr);
    assign ad_in = !psen_n ? code_val(latched) :
                   !rd_n   ? dmem[latched[7:0]] : 8'hEE;

    int n_ale, n_psen, n_rd, n_wr, n_busy, n_done, n_overlap, n_lane_bad, n_hi_bad;

    task automatic clear_mon();
        n_ale = 0; n_psen = 0; n_rd = 0; n_wr = 0; n_busy = 0; n_done = 0;
        n_overlap = 0; n_lane_bad = 0; n_hi_bad = 0;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (ale) n_ale++;
            if (!psen_n) n_psen++;
            if (!rd_n) n_rd++;
            if (!wr_n) n_wr++;
            if (!req_ready) n_busy++;
            if (done) n_done++;
            if (32'(ale) + 32'(!psen_n) + 32'(!rd_n) + 32'(!wr_n) > 1) n_overlap++;
            if ((!psen_n || !rd_n) && ad_oe) n_lane_bad++;
            if (!wr_n && (!ad_oe || ad_out != exp_wdata)) n_lane_bad++;
            if (ale_d && !ale) latched = {hi_addr, ad_out};
            if ((!psen_n || !rd_n || !wr_n) && hi_addr != latched[15:8]) n_hi_bad++;
            if (!wr_d && wr_n) begin
                if (!ad_oe) n_lane_bad++;
                dmem[latched[7:0]] = ad_out;
            end
            ale_d = ale;
            wr_d  = wr_n;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // one access; hold=1 keeps req_valid asserted until done
    task automatic run_access(input logic sp, input logic we, input logic [15:0] a,
                              input logic [7:0] wd, input logic exp_int,
                              input logic is_read, input logic [7:0] exp_rd,
                              input bit hold, input string tag);
        int lat;
        int exp_lat;
        int exp_cyc;
        @(negedge clk);
        clear_mon();
        exp_wdata = wd;
        req_space = sp; req_we = we; req_addr = a; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        if (!hold) req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        req_valid = 1'b0;
        @(negedge clk);
        #1;
        exp_lat = exp_int ? 2 : 7;
        exp_cyc = exp_int ? 0 : 3;
        check(lat == exp_lat, {tag, " R10 done latency"}, lat, exp_lat);
        check(n_busy == exp_lat && n_done == 1, {tag, " R10 busy cycles / single done"},
              n_busy * 16 + n_done, exp_lat * 16 + 1);
        check(n_ale == (exp_int ? 0 : 2), {tag, " R2 ale length (R7 none if internal)"}, n_ale, exp_int ? 0 : 2);
        if (!sp) begin
            check(n_psen == exp_cyc && n_rd == 0 && n_wr == 0,
                  {tag, " R3 psen length, R11 no rd/wr"}, n_psen, exp_cyc);
        end else if (we) begin
            check(n_wr == 3 && n_rd == 0 && n_psen == 0,
                  {tag, " R5 wr length, R11 no psen"}, n_wr, 3);
        end else begin
            check(n_rd == 3 && n_psen == 0 && n_wr == 0,
                  {tag, " R4 rd length, R11 no psen"}, n_rd, 3);
        end
        check(n_overlap == 0, {tag, " R8 strobe overlap"}, n_overlap, 0);
        check(n_lane_bad == 0, {tag, " R3/R5 lane direction"}, n_lane_bad, 0);
        check(n_hi_bad == 0, {tag, " R9 high byte steady"}, n_hi_bad, 0);
        if (!exp_int) check(latched == a, {tag, " R2 latched address"}, latched, a);
        if (is_read) check(rdata == exp_rd, {tag, " read data"}, rdata, exp_rd);
        check(req_ready == 1'b1, {tag, " R10 ready after done"}, req_ready, 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!ale && psen_n && rd_n && wr_n && !ad_oe && !done && req_ready,
              "R1 reset outputs", {ale, psen_n, rd_n, wr_n, ad_oe, done, req_ready}, 7'b0111001);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!ale && psen_n && rd_n && wr_n && !ad_oe && !done && req_ready,
              "R1 after reset", {ale, psen_n, rd_n, wr_n, ad_oe, done, req_ready}, 7'b0111001);
    endtask

    task automatic t_code_paths();
        ext_only_n = 1'b1;
        run_access(1'b0, 1'b0, 16'h1234, 8'h00, 1'b0, 1'b1, code_val(16'h1234), 1'b0, "R3 ext code");
        run_access(1'b0, 1'b0, 16'h0FFF, 8'h00, 1'b1, 1'b1, rom_val(12'hFFF), 1'b0, "R7 rom top");
        run_access(1'b0, 1'b0, 16'h0ABC, 8'h00, 1'b1, 1'b1, rom_val(12'hABC), 1'b0, "R7 rom mid");
        run_access(1'b0, 1'b0, 16'h1000, 8'h00, 1'b0, 1'b1, code_val(16'h1000), 1'b0, "R7 boundary ext");
    endtask

    task automatic t_forced_ext();
        ext_only_n = 1'b0;
        run_access(1'b0, 1'b0, 16'h0000, 8'h00, 1'b0, 1'b1, code_val(16'h0000), 1'b0, "R6 forced 0000");
        run_access(1'b0, 1'b0, 16'h0FFF, 8'h00, 1'b0, 1'b1, code_val(16'h0FFF), 1'b0, "R6 forced 0FFF");
        ext_only_n = 1'b1;
    endtask

    task automatic t_data();
        run_access(1'b1, 1'b1, 16'h0123, 8'hA5, 1'b0, 1'b0, 8'h00, 1'b0, "R5 write 0123");
        run_access(1'b1, 1'b1, 16'hFF00, 8'h3C, 1'b0, 1'b0, 8'h00, 1'b0, "R5 write FF00");
        run_access(1'b1, 1'b0, 16'h0123, 8'h00, 1'b0, 1'b1, 8'hA5, 1'b0, "R4 read 0123");
        run_access(1'b1, 1'b0, 16'hFF00, 8'h00, 1'b0, 1'b1, 8'h3C, 1'b0, "R4 read FF00");
        run_access(1'b1, 1'b0, 16'h0040, 8'h00, 1'b0, 1'b1, 8'h40 ^ 8'hC3, 1'b0, "R11 data below 4K");
    endtask

    task automatic t_code_we();
        // code request with write bit: still a psen read, data memory untouched
        ext_only_n = 1'b0;
        run_access(1'b0, 1'b1, 16'h0123, 8'h77, 1'b0, 1'b1, code_val(16'h0123), 1'b0, "R11 code we");
        ext_only_n = 1'b1;
        run_access(1'b1, 1'b0, 16'h0123, 8'h00, 1'b0, 1'b1, 8'hA5, 1'b0, "R11 dmem unchanged");
    endtask

    task automatic t_busy();
        run_access(1'b1, 1'b0, 16'hFF00, 8'h00, 1'b0, 1'b1, 8'h3C, 1'b1, "R10 held valid");
        run_access(1'b0, 1'b0, 16'h0100, 8'h00, 1'b1, 1'b1, rom_val(12'h100), 1'b1, "R10 held internal");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) dmem[i] = 8'(i) ^ 8'hC3;
        clear_mon();
        t_reset();
        t_code_paths();
        t_forced_ext();
        t_data();
        t_code_we();
        t_busy();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        wait (cyc > 20000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule